// File: doc/BRIEF.md
# Host Read Word Prefetch Buffer

This block answers narrow host reads from a single buffered 32-bit word. The host reads either bytes (byte mode) or halfwords (halfword mode). When a read lands outside the aligned 32-bit word that is currently buffered, the block issues one 32-bit read on the initiator side. It stores all four returned bytes and hands the requested lane back to the host. Later reads inside the same aligned word are served from the buffer and cause no initiator traffic. In effect the block is a one-entry read cache whose tag is the aligned word index of the host address.

The initiator address is counted in halfwords. A fetch therefore goes to the configured base plus twice the word index of the host address. The buffer is dropped when the configuration changes (the mode or the base) or when a host write touches the buffered word. A write that touches the word being fetched still lets the pending read complete with the fetched data. In that case the word is not kept.

Top module: `rd_prefetch_buf`

## Requirements
- R1: While and after reset, `host_rvalid_o`, `init_req_o` and `busy_o` are 0 and the buffer is empty, so the first read after reset fetches.
- R2: A missing read issues one initiator read at `base_i + 2*word_index`. `init_req_o` and `init_addr_o` hold until the cycle `init_rvalid_i` is sampled high. Word index is `host_addr_i[7:2]` in byte mode and `host_addr_i[7:1]` in halfword mode.
- R3: A read inside the buffered word raises `host_rvalid_o` in the cycle after it is sampled and starts no initiator read.
- R4: In byte mode (`mode16_i`=0), `host_addr_i[1:0]`=k returns bits [8k+7:8k] of the word on `host_rdata_o[7:0]`, with `host_rdata_o[15:8]`=0.
- R5: In halfword mode (`mode16_i`=1), `host_addr_i[0]`=0 returns word bits [15:0] and `host_addr_i[0]`=1 returns bits [31:16].
- R6: In byte mode, byte 4 read after bytes 0 to 3 leaves the buffered word and fetches at base+2.
- R7: In halfword mode, halfwords 0 and 1 share the fetch at base+0, and halfwords 2 and 3 share the fetch at base+2.
- R8: On a miss, `busy_o` is high from the cycle after the read until the data returns. `host_rvalid_o` pulses in the cycle after `init_rvalid_i` is sampled. Host reads presented while `busy_o` is high are ignored.
- R9: An idle host write (`host_wr_i`) to an address in the buffered word empties the buffer. A write to another word does not.
- R10: A change of `mode16_i` or `base_i` empties the buffer, including when it coincides with a read.
- R11: A host write that overlaps the word being fetched, in any fetch cycle including the return cycle, still lets the pending read return the fetched data. The next read of that word fetches again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode16_i | input | 1 | 0: byte host reads, 1: halfword host reads |
| base_i | input | INIT_AW | Initiator base address, in halfword units |
| host_rd_i | input | 1 | Host read strobe, one cycle |
| host_wr_i | input | 1 | Host write event, used for invalidation |
| host_addr_i | input | HOST_AW | Host address, byte or halfword units by mode |
| host_rdata_o | output | 16 | Read data to host |
| host_rvalid_o | output | 1 | Read data valid, one-cycle pulse |
| busy_o | output | 1 | Fetch in flight; host read stalled |
| init_req_o | output | 1 | Initiator 32-bit read request, held until data |
| init_addr_o | output | INIT_AW | Initiator read address, halfword units |
| init_rdata_i | input | 32 | Initiator read data |
| init_rvalid_i | input | 1 | Initiator read data valid |

## Verification
The fill of a returning word and an invalidating host write can fall in the same cycle. The block must still deliver the fetched lane to the waiting read, but it must not keep the word. The bench provokes this by letting its initiator responder raise the write strobe in the very cycle it returns data, with the host address still pointing into the fetched word. It also places a write in a middle cycle of a fetch. The result is judged by the returned data matching the memory model and by the next read of a neighbouring lane in that word producing a new initiator read at the same address.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_FETCH} pfb_state_e;
endpackage

// File: rtl/pfb_addr_map.sv
module pfb_addr_map #(
  parameter int HOST_AW = 8,
  localparam int IDX_W = HOST_AW - 1
) (
  input  logic               mode16_i,
  input  logic [HOST_AW-1:0] addr_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic [1:0]         lane_o
);
  always_comb begin
    if (mode16_i) begin
      idx_o  = addr_i[HOST_AW-1:1];
      lane_o = {addr_i[0], 1'b0};
    end else begin
      idx_o  = {1'b0, addr_i[HOST_AW-1:2]};
      lane_o = addr_i[1:0];
    end
  end
endmodule

// File: rtl/pfb_lane_sel.sv
module pfb_lane_sel (
  input  logic [31:0] word_i,
  input  logic [1:0]  lane_i,
  input  logic        mode16_i,
  output logic [15:0] data_o
);
  always_comb begin
    if (mode16_i) begin
      data_o = lane_i[1] ? word_i[31:16] : word_i[15:0];
    end else begin
      unique case (lane_i)
        2'd0:    data_o = {8'h00, word_i[7:0]};
        2'd1:    data_o = {8'h00, word_i[15:8]};
        2'd2:    data_o = {8'h00, word_i[23:16]};
        default: data_o = {8'h00, word_i[31:24]};
      endcase
    end
  end
endmodule

// File: rtl/pfb_tag_ctrl.sv
module pfb_tag_ctrl #(
  parameter int IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_chg_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             busy_i,
  input  logic             start_i,
  input  logic             fill_i,
  output logic             hit_o
);
  logic             valid_q, stale_q;
  logic [IDX_W-1:0] tag_q, pend_q;
  logic             wr_buf, wr_pend;

  assign wr_buf  = wr_i && valid_q && (idx_i == tag_q);
  assign wr_pend = wr_i && busy_i && (idx_i == pend_q);
  assign hit_o   = valid_q && (idx_i == tag_q) && !cfg_chg_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      stale_q <= 1'b0;
      tag_q   <= '0;
      pend_q  <= '0;
    end else begin
      if (start_i) begin
        pend_q  <= idx_i;
        stale_q <= 1'b0;
      end else if (busy_i && (wr_pend || cfg_chg_i)) begin
        stale_q <= 1'b1;
      end
      // a fill that saw an overlapping write or a config change is not kept
      if (fill_i) begin
        valid_q <= !(stale_q || wr_pend || cfg_chg_i);
        tag_q   <= pend_q;
      end else if (cfg_chg_i || wr_buf) begin
        valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rd_prefetch_buf.sv
module rd_prefetch_buf
  import pfb_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter int INIT_AW = 22
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode16_i,
  input  logic [INIT_AW-1:0] base_i,
  input  logic               host_rd_i,
  input  logic               host_wr_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  output logic [15:0]        host_rdata_o,
  output logic               host_rvalid_o,
  output logic               busy_o,
  output logic               init_req_o,
  output logic [INIT_AW-1:0] init_addr_o,
  input  logic [31:0]        init_rdata_i,
  input  logic               init_rvalid_i
);
  localparam int IDX_W = HOST_AW - 1;

  pfb_state_e         state_q;
  logic [IDX_W-1:0]   idx;
  logic [1:0]         lane, pend_lane_q, sel_lane;
  logic               pend_mode_q, sel_mode;
  logic [31:0]        buf_word_q, sel_word;
  logic [15:0]        sel_data;
  logic               mode_q;
  logic [INIT_AW-1:0] base_q, addr_q;
  logic [15:0]        rdata_q;
  logic               rvalid_q;
  logic               cfg_chg, hit, fetching, fill, rd_acc, miss_start;

  assign fetching   = (state_q == ST_FETCH);
  assign fill       = fetching && init_rvalid_i;
  assign rd_acc     = host_rd_i && !fetching;
  assign miss_start = rd_acc && !hit;
  assign cfg_chg    = (mode16_i != mode_q) || (base_i != base_q);

  pfb_addr_map #(.HOST_AW(HOST_AW)) u_map (
    .mode16_i (mode16_i),
    .addr_i   (host_addr_i),
    .idx_o    (idx),
    .lane_o   (lane)
  );

  pfb_tag_ctrl #(.IDX_W(IDX_W)) u_tag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_chg_i (cfg_chg),
    .wr_i      (host_wr_i),
    .idx_i     (idx),
    .busy_i    (fetching),
    .start_i   (miss_start),
    .fill_i    (fill),
    .hit_o     (hit)
  );

  // one extractor shared by hit path and fill path
  assign sel_word = fill ? init_rdata_i : buf_word_q;
  assign sel_lane = fill ? pend_lane_q  : lane;
  assign sel_mode = fill ? pend_mode_q  : mode16_i;

  pfb_lane_sel u_sel (
    .word_i   (sel_word),
    .lane_i   (sel_lane),
    .mode16_i (sel_mode),
    .data_o   (sel_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pend_lane_q <= '0;
      pend_mode_q <= 1'b0;
      buf_word_q  <= '0;
      mode_q      <= 1'b0;
      base_q      <= '0;
      addr_q      <= '0;
      rdata_q     <= '0;
      rvalid_q    <= 1'b0;
    end else begin
      mode_q   <= mode16_i;
      base_q   <= base_i;
      rvalid_q <= 1'b0;
      if (fill) begin
        state_q    <= ST_IDLE;
        buf_word_q <= init_rdata_i;
        rdata_q    <= sel_data;
        rvalid_q   <= 1'b1;
      end else if (rd_acc) begin
        if (hit) begin
          rdata_q  <= sel_data;
          rvalid_q <= 1'b1;
        end else begin
          state_q     <= ST_FETCH;
          pend_lane_q <= lane;
          pend_mode_q <= mode16_i;
          addr_q      <= base_i + INIT_AW'({idx, 1'b0});
        end
      end
    end
  end

  assign host_rdata_o  = rdata_q;
  assign host_rvalid_o = rvalid_q;
  assign busy_o        = fetching;
  assign init_req_o    = fetching;
  assign init_addr_o   = addr_q;
endmodule

// File: rtl/pfb_checker.sv
module pfb_checker #(
  parameter int INIT_AW = 22
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               host_rd_i,
  input logic               host_rvalid_o,
  input logic               busy_o,
  input logic               init_req_o,
  input logic [INIT_AW-1:0] init_addr_o,
  input logic               init_rvalid_i
);
  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_req_o && !init_rvalid_i |=> init_req_o && $stable(init_addr_o));

  assert_req_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_req_o) |-> $past(host_rd_i));

  assert_fill_resp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_req_o && init_rvalid_i |=> host_rvalid_o && !init_req_o);

  assert_resp_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rvalid_o |-> $past(host_rd_i) || $past(init_rvalid_i));

  assert_resp_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rvalid_o |-> !busy_o);
endmodule

bind rd_prefetch_buf pfb_checker #(.INIT_AW(INIT_AW)) u_pfb_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .host_rd_i     (host_rd_i),
  .host_rvalid_o (host_rvalid_o),
  .busy_o        (busy_o),
  .init_req_o    (init_req_o),
  .init_addr_o   (init_addr_o),
  .init_rvalid_i (init_rvalid_i)
);

// File: tb/tb_rd_prefetch_buf.sv
`timescale 1ns/1ps
module tb_rd_prefetch_buf;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        mode16_i;
  logic [21:0] base_i;
  logic        host_rd_i, wr_a, wr_b, host_wr_i;
  logic [7:0]  host_addr_i;
  logic [15:0] host_rdata_o;
  logic        host_rvalid_o, busy_o, init_req_o;
  logic [21:0] init_addr_o;
  logic [31:0] init_rdata_i;
  logic        init_rvalid_i;

  always #2.5 clk_i = ~clk_i;
  assign host_wr_i = wr_a | wr_b;

  rd_prefetch_buf dut (.*);

  typedef struct {logic [15:0] data; bit hit; int cyc; string req;} item_t;
  item_t q[$];
  int n_run = 0, n_fail = 0, cyc = 0, fetch_cnt = 0;
  logic [21:0] last_iaddr;
  bit wr_on_ret = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] hwval(input logic [21:0] x);
    logic [31:0] t;
    t = ({10'b0, x} * 32'h9E37) ^ 32'h5A3C;
    return t[15:0];
  endfunction

  function automatic logic [15:0] exp_rd(input logic [7:0] a);
    logic [21:0] ia;
    logic [15:0] hw;
    if (!mode16_i) begin
      ia = base_i + 22'({a[7:2], 1'b0}) + 22'(a[1]);
      hw = hwval(ia);
      return a[0] ? {8'h00, hw[15:8]} : {8'h00, hw[7:0]};
    end
    ia = base_i + 22'({a[7:1], 1'b0}) + 22'(a[0]);
    return hwval(ia);
  endfunction

  // initiator responder: two-cycle latency
  initial begin
    init_rvalid_i = 1'b0;
    init_rdata_i  = '0;
    wr_b          = 1'b0;
    forever begin
      @(negedge clk_i);
      if (init_req_o) begin
        fetch_cnt++;
        last_iaddr = init_addr_o;
        repeat (2) @(negedge clk_i);
        init_rdata_i  = {hwval(last_iaddr + 22'd1), hwval(last_iaddr)};
        init_rvalid_i = 1'b1;
        wr_b          = wr_on_ret;
        @(negedge clk_i);
        init_rvalid_i = 1'b0;
        wr_b          = 1'b0;
      end
    end
  end

  // monitor: scoreboard compare
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && host_rvalid_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8", "unexpected response", 1, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(host_rdata_o == it.data, it.req, "read data", host_rdata_o, it.data);
          if (it.hit) chk(cyc == it.cyc, "R3", "hit latency cycle", cyc, it.cyc);
        end
      end
    end
  end

  task automatic rd(input logic [7:0] a, input bit hit, input logic [21:0] eia,
                    input bit wr_mid, input string rq);
    int f0;
    int guard;
    item_t it;
    f0 = fetch_cnt;
    @(negedge clk_i);
    host_addr_i = a;
    host_rd_i   = 1'b1;
    it.data = exp_rd(a); it.hit = hit; it.cyc = cyc + 1; it.req = rq;
    q.push_back(it);
    @(negedge clk_i);
    host_rd_i = 1'b0;
    if (wr_mid) wr_a = 1'b1;
    @(negedge clk_i);
    wr_a = 1'b0;
    guard = 0;
    while (q.size() != 0 && guard < 100) begin
      @(negedge clk_i);
      guard++;
    end
    chk(q.size() == 0, rq, "response missing", q.size(), 0);
    chk((fetch_cnt - f0) == (hit ? 0 : 1), rq, "fetch count", fetch_cnt - f0, hit ? 0 : 1);
    if (!hit) chk(last_iaddr == eia, rq, "fetch address", last_iaddr, eia);
  endtask

  task automatic wr(input logic [7:0] a);
    @(negedge clk_i);
    host_addr_i = a;
    wr_a = 1'b1;
    @(negedge clk_i);
    wr_a = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; mode16_i = 1'b0; base_i = 22'h100;
    host_rd_i = 1'b0; wr_a = 1'b0; host_addr_i = '0;
    repeat (3) @(negedge clk_i);
    chk(!host_rvalid_o && !init_req_o && !busy_o, "R1", "reset outputs",
        {host_rvalid_o, init_req_o, busy_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!host_rvalid_o && !init_req_o && !busy_o, "R1", "post-reset outputs",
        {host_rvalid_o, init_req_o, busy_o}, 0);

    // byte mode
    rd(8'd0, 0, 22'h100, 0, "R1");
    rd(8'd1, 1, 0, 0, "R4");
    rd(8'd2, 1, 0, 0, "R4");
    rd(8'd3, 1, 0, 0, "R3");
    rd(8'd4, 0, 22'h102, 0, "R6");
    rd(8'd5, 1, 0, 0, "R3");
    wr(8'd6);
    rd(8'd5, 0, 22'h102, 0, "R9");
    wr(8'd0);
    rd(8'd7, 1, 0, 0, "R9");
    @(negedge clk_i); base_i = 22'h200;
    rd(8'd7, 0, 22'h202, 0, "R10");
    rd(8'd6, 1, 0, 0, "R4");

    // halfword mode; same word index as buffered, must refetch
    @(negedge clk_i); mode16_i = 1'b1;
    rd(8'd3, 0, 22'h202, 0, "R10");
    rd(8'd2, 1, 0, 0, "R7");
    rd(8'd0, 0, 22'h200, 0, "R7");
    rd(8'd1, 1, 0, 0, "R5");

    // write coinciding with fill return
    wr_on_ret = 1;
    rd(8'd4, 0, 22'h204, 0, "R11");
    wr_on_ret = 0;
    rd(8'd5, 0, 22'h204, 0, "R11");
    rd(8'd4, 1, 0, 0, "R5");
    // write in a middle fetch cycle
    rd(8'd6, 0, 22'h206, 1, "R11");
    rd(8'd7, 0, 22'h206, 0, "R11");

    // read while busy is ignored
    begin
      int f0;
      int guard;
      item_t it;
      f0 = fetch_cnt;
      @(negedge clk_i);
      host_addr_i = 8'd8; host_rd_i = 1'b1;
      it.data = exp_rd(8'd8); it.hit = 0; it.cyc = 0; it.req = "R8";
      q.push_back(it);
      @(negedge clk_i);
      chk(busy_o == 1'b1, "R8", "busy during fetch", busy_o, 1);
      host_addr_i = 8'd0; host_rd_i = 1'b1;
      @(negedge clk_i);
      host_rd_i = 1'b0;
      guard = 0;
      while (q.size() != 0 && guard < 100) begin
        @(negedge clk_i);
        guard++;
      end
      repeat (6) @(negedge clk_i);
      chk(fetch_cnt - f0 == 1, "R8", "fetches with busy read", fetch_cnt - f0, 1);
      chk(last_iaddr == 22'h208, "R8", "fetch address", last_iaddr, 22'h208);
      chk(busy_o == 1'b0, "R8", "busy after fill", busy_o, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule